// File: doc/BRIEF.md
# Sleep-Gated Dual-Rail Pipeline Stage

This block is one stage of a dual-rail, delay-insensitive style pipeline, modelled cycle by cycle. Each data bit travels on a true rail and a false rail. Exactly one rail high is a DATA value, and both rails low is NULL. The stage never passes a NULL wavefront through its gates. Instead, a single sleep signal forces every register bit and every logic gate in the stage low, and that low state is the NULL.

Completion is detected at the register inputs rather than the register outputs. The stage therefore wakes only when a whole DATA wavefront is present at its inputs and the downstream side asks for DATA. A wavefront that is still forming never reaches the logic behind the register. Each register bit is a 1-of-2 gate whose output feeds back into one of its own inputs, so once set it holds until the stage sleeps again. The same acknowledge that sleeps the register also sleeps the logic placed after it.

Flow control follows the four-phase DATA/NULL handshake instead of valid/ready. The request signals play the role of ready, and a complete DATA or NULL wavefront plays the role of valid. Back-pressure works as follows. While the downstream request stays low, no new DATA is accepted. While it stays high, DATA that has already been accepted is held. Upstream must not change a DATA wavefront until the stage's request has fallen.

Top module: `slpstg`

## Requirements
- R1: During and right after reset, `up_rfd` is 1 (stage asleep, asking for DATA) and every bit of `out_t` and `out_f` is 0 (all NULL).
- R2: Bit i is DATA 1 when `in_t[i]=1, in_f[i]=0`, DATA 0 when `in_t[i]=0, in_f[i]=1`, NULL when both are 0, and illegal when both are 1. An illegal bit never counts as DATA.
- R3: When `up_rfd` is 1, every input bit is DATA and `dn_rfd` is 1, then at the next clock edge `up_rfd` falls to 0 and the outputs carry the computed DATA wavefront.
- R4: While `up_rfd` is 1, if any input bit is NULL or illegal, then `up_rfd` stays 1 and the outputs stay all NULL, whatever the other bits carry.
- R5: While `up_rfd` is 1 and `dn_rfd` is 0, no capture happens, even for a complete DATA wavefront. `up_rfd` stays 1 and the outputs stay NULL.
- R6: Once DATA has been captured, the outputs hold that value unchanged while `up_rfd` stays 0, including after the inputs return to NULL.
- R7: When `up_rfd` is 0, every input bit is NULL and `dn_rfd` is 0, then at the next clock edge `up_rfd` rises to 1 and every output rail goes to 0. Whenever `up_rfd` is 1, the outputs are all NULL.
- R8: While `up_rfd` is 0, the stage does not sleep if any input rail is still high or if `dn_rfd` is 1.
- R9: With the default FUNC=2, output bit i is input bit i XOR input bit i+1, and the top bit passes unchanged (a binary-to-Gray mapping). FUNC=0 passes the bits through and FUNC=1 complements them.
- R10: The outputs never carry an illegal bit. They are always either entirely NULL or entirely DATA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; puts the stage to sleep |
| in_t | input | W | True rails of the incoming wavefront |
| in_f | input | W | False rails of the incoming wavefront |
| up_rfd | output | 1 | Acknowledge to upstream: 1 asks for DATA (stage asleep), 0 asks for NULL |
| dn_rfd | input | 1 | Acknowledge from downstream: 1 asks for DATA, 0 asks for NULL |
| out_t | output | W | True rails of the outgoing wavefront |
| out_f | output | W | False rails of the outgoing wavefront |

## Verification
The hardest case to reach is a wavefront that is almost complete. All but one bit are already DATA, or one bit shows both rails, while the downstream request is high. Only the early completion check stops the logic from waking at that moment. The bench builds exactly this input: it clears or doubles the rails of a single chosen bit in an otherwise full pattern. It then checks that the stage stays asleep, completes the missing bit, and sees the capture happen on the very next edge. A separate scenario keeps partial DATA on the inputs while the downstream request is low, to show that release waits for every rail to fall.

// File: rtl/slpstg_pkg.sv
`timescale 1ns/1ps
package slpstg_pkg;
  // Function applied by the logic that sits behind the register.
  typedef enum int {
    FN_PASS   = 0,
    FN_INVERT = 1,
    FN_GRAY   = 2
  } stage_fn_e;

  // Request polarity on the handshake wires.
  localparam logic REQ_DATA = 1'b1;
  localparam logic REQ_NULL = 1'b0;
endpackage

// File: rtl/slpstg_ecd.sv
`timescale 1ns/1ps
// Early completion detector: it watches the register inputs and holds the
// acknowledge state with hysteresis.
module slpstg_ecd
  import slpstg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  input  logic         dn_rfd,
  output logic         rfd_q,
  output logic         sleep_nxt
);
  localparam int LAST = W - 1;

  logic [W-1:0] bit_dat;
  logic [W-1:0] bit_nul;
  logic [W-1:0] run_dat;
  logic [W-1:0] run_nul;

  // Per-bit detectors followed by a chained reduction.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_dat[i] = in_t[i] ^ in_f[i];
    assign bit_nul[i] = ~(in_t[i] | in_f[i]);
    if (i == 0) begin : g_first
      assign run_dat[i] = bit_dat[i];
      assign run_nul[i] = bit_nul[i];
    end else begin : g_rest
      assign run_dat[i] = run_dat[i-1] & bit_dat[i];
      assign run_nul[i] = run_nul[i-1] & bit_nul[i];
    end
  end

  logic wave_dat;
  logic wave_nul;
  logic rfd_d;

  assign wave_dat = run_dat[LAST];
  assign wave_nul = run_nul[LAST];

  always_comb begin
    rfd_d = rfd_q;
    if (rfd_q == REQ_DATA) begin
      if (wave_dat && dn_rfd == REQ_DATA) rfd_d = REQ_NULL;
    end else begin
      if (wave_nul && dn_rfd == REQ_NULL) rfd_d = REQ_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rfd_q <= REQ_DATA;
    else        rfd_q <= rfd_d;
  end

  // The register sleeps in the same cycle that the acknowledge requests DATA.
  assign sleep_nxt = rfd_d;
endmodule

// File: rtl/slpstg_reg.sv
`timescale 1ns/1ps
// Register of sleep-capable 1-of-2 gates; each rail feeds back on itself.
module slpstg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep_nxt,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  output logic [W-1:0] q_t,
  output logic [W-1:0] q_f
);
  for (genvar i = 0; i < W; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_t[i] <= 1'b0;
        q_f[i] <= 1'b0;
      end else if (sleep_nxt) begin
        q_t[i] <= 1'b0;
        q_f[i] <= 1'b0;
      end else begin
        q_t[i] <= q_t[i] | in_t[i];
        q_f[i] <= q_f[i] | in_f[i];
      end
    end
  end
endmodule

// File: rtl/slpstg_logic.sv
`timescale 1ns/1ps
// Sleep-capable dual-rail logic with no hysteresis: each output is its set
// condition while awake and is forced low while asleep.
module slpstg_logic
  import slpstg_pkg::*;
#(
  parameter int W    = 8,
  parameter int FUNC = FN_GRAY
) (
  input  logic         sleep,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  output logic [W-1:0] y_t,
  output logic [W-1:0] y_f
);
  localparam int LAST = W - 1;

  logic [W-1:0] set_t;
  logic [W-1:0] set_f;

  for (genvar i = 0; i < W; i++) begin : g_gate
    if (FUNC == FN_INVERT) begin : g_inv
      assign set_t[i] = a_f[i];
      assign set_f[i] = a_t[i];
    end else if (FUNC == FN_GRAY && i < LAST) begin : g_xor
      assign set_t[i] = (a_t[i] & a_f[i+1]) | (a_f[i] & a_t[i+1]);
      assign set_f[i] = (a_t[i] & a_t[i+1]) | (a_f[i] & a_f[i+1]);
    end else begin : g_pass
      assign set_t[i] = a_t[i];
      assign set_f[i] = a_f[i];
    end
    assign y_t[i] = ~sleep & set_t[i];
    assign y_f[i] = ~sleep & set_f[i];
  end
endmodule

// File: rtl/slpstg.sv
`timescale 1ns/1ps
module slpstg
  import slpstg_pkg::*;
#(
  parameter int W    = 8,
  parameter int FUNC = FN_GRAY
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  output logic         up_rfd,
  input  logic         dn_rfd,
  output logic [W-1:0] out_t,
  output logic [W-1:0] out_f
);
  logic         ack_q;
  logic         reg_sleep;
  logic [W-1:0] r_t;
  logic [W-1:0] r_f;

  slpstg_ecd #(.W(W)) u_ecd (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_t      (in_t),
    .in_f      (in_f),
    .dn_rfd    (dn_rfd),
    .rfd_q     (ack_q),
    .sleep_nxt (reg_sleep)
  );

  slpstg_reg #(.W(W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_nxt (reg_sleep),
    .in_t      (in_t),
    .in_f      (in_f),
    .q_t       (r_t),
    .q_f       (r_f)
  );

  // The logic after the register is put to sleep by this stage's acknowledge.
  slpstg_logic #(.W(W), .FUNC(FUNC)) u_logic (
    .sleep (ack_q),
    .a_t   (r_t),
    .a_f   (r_f),
    .y_t   (out_t),
    .y_f   (out_f)
  );

  assign up_rfd = ack_q;
endmodule

// File: rtl/slpstg_chk.sv
`timescale 1ns/1ps
module slpstg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] in_t,
  input logic [W-1:0] in_f,
  input logic         up_rfd,
  input logic         dn_rfd,
  input logic [W-1:0] out_t,
  input logic [W-1:0] out_f
);
  logic in_full;
  logic in_empty;
  logic out_empty;
  logic out_full;

  assign in_full   = &(in_t ^ in_f);
  assign in_empty  = ~|(in_t | in_f);
  assign out_empty = ~|(out_t | out_f);
  assign out_full  = &(out_t ^ out_f);

  p_reset_null_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (up_rfd && out_empty));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rfd && in_full && dn_rfd) |=> (!up_rfd && out_full));

  p_partial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rfd && !in_full) |=> (up_rfd && out_empty));

  p_backpressure_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rfd && !dn_rfd) |=> up_rfd);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_rfd && !(in_empty && !dn_rfd)) |=> (!up_rfd && $stable(out_t) && $stable(out_f)));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_rfd && in_empty && !dn_rfd) |=> (up_rfd && out_empty));

  p_asleep_null_r7: assert property (@(posedge clk) disable iff (!rst_n)
    up_rfd |-> out_empty);

  p_no_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_t & out_f) == '0);

  p_whole_wave_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_empty || out_full));
endmodule

bind slpstg slpstg_chk #(.W(W)) u_slpstg_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .in_t   (in_t),
  .in_f   (in_f),
  .up_rfd (up_rfd),
  .dn_rfd (dn_rfd),
  .out_t  (out_t),
  .out_f  (out_f)
);

// File: tb/slpstg_bench.sv
`timescale 1ns/1ps
module slpstg_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] in_t = '0;
  logic [W-1:0] in_f = '0;
  logic         dn_rfd = 1'b1;
  logic         up_rfd;
  logic [W-1:0] out_t;
  logic [W-1:0] out_f;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  slpstg #(.W(W), .FUNC(2)) u_slpstg (
    .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f),
    .up_rfd(up_rfd), .dn_rfd(dn_rfd), .out_t(out_t), .out_f(out_f)
  );

  function automatic logic [W-1:0] gray(input logic [W-1:0] v);
    return v ^ (v >> 1);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s up_rfd actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [W-1:0] et, input logic [W-1:0] ef);
    checks++;
    if (out_t !== et || out_f !== ef) begin
      errors++;
      $display("FAIL %s out actual=%h/%h expected=%h/%h", req, out_t, out_f, et, ef);
    end
  endtask

  task automatic drive_data(input logic [W-1:0] v);
    in_t = v;
    in_f = ~v;
  endtask

  task automatic drive_null();
    in_t = '0;
    in_f = '0;
  endtask

  // A full capture and release cycle with checks on both halves.
  task automatic cycle_value(input string req, input logic [W-1:0] v);
    dn_rfd = 1'b1;
    drive_data(v);
    step();
    chk_bit(req, up_rfd, 1'b0);
    chk_out(req, gray(v), ~gray(v));
    drive_null();
    dn_rfd = 1'b0;
    step();
    chk_bit("R7", up_rfd, 1'b1);
    chk_out("R7", '0, '0);
    dn_rfd = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive_null();
    dn_rfd = 1'b1;
    step();
    chk_bit("R1", up_rfd, 1'b1);
    chk_out("R1", '0, '0);
    rst_n = 1'b1;
    step();
    chk_bit("R1", up_rfd, 1'b1);
    chk_out("R1", '0, '0);
  endtask

  task automatic t_patterns();
    cycle_value("R3", 8'h00);
    cycle_value("R9", 8'hFF);
    cycle_value("R9", 8'hA5);
    cycle_value("R2", 8'h80);
    cycle_value("R3", 8'h3C);
  endtask

  task automatic t_partial();
    logic [W-1:0] v = 8'h96;
    dn_rfd = 1'b1;
    drive_data(v);
    in_t[5] = 1'b0;
    in_f[5] = 1'b0;               // one bit still NULL
    step();
    chk_bit("R4", up_rfd, 1'b1);
    chk_out("R4", '0, '0);
    in_t[5] = 1'b1;
    in_f[5] = 1'b1;               // illegal bit is not DATA
    step();
    chk_bit("R2", up_rfd, 1'b1);
    chk_out("R2", '0, '0);
    drive_data(v);                // wavefront completes
    step();
    chk_bit("R4", up_rfd, 1'b0);
    chk_out("R4", gray(v), ~gray(v));
    drive_null();
    dn_rfd = 1'b0;
    step();
    chk_bit("R7", up_rfd, 1'b1);
    dn_rfd = 1'b1;
  endtask

  task automatic t_backpressure();
    logic [W-1:0] v = 8'h5B;
    dn_rfd = 1'b0;
    drive_data(v);
    step();
    step();
    chk_bit("R5", up_rfd, 1'b1);
    chk_out("R5", '0, '0);
    dn_rfd = 1'b1;
    step();
    chk_bit("R5", up_rfd, 1'b0);
    chk_out("R5", gray(v), ~gray(v));
    drive_null();
    dn_rfd = 1'b0;
    step();
    dn_rfd = 1'b1;
  endtask

  task automatic t_hold_release();
    logic [W-1:0] v = 8'hC3;
    dn_rfd = 1'b1;
    drive_data(v);
    step();
    drive_null();                 // inputs gone, downstream still wants DATA
    for (int k = 0; k < 3; k++) begin
      step();
      chk_bit("R6", up_rfd, 1'b0);
      chk_out("R6", gray(v), ~gray(v));
    end
    dn_rfd = 1'b0;
    in_t = 8'h01;                 // one rail still high
    step();
    chk_bit("R8", up_rfd, 1'b0);
    chk_out("R8", gray(v), ~gray(v));
    drive_null();
    step();
    chk_bit("R7", up_rfd, 1'b1);
    chk_out("R10", '0, '0);
    dn_rfd = 1'b1;
  endtask

  task automatic t_random();
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] v = W'($urandom);
      cycle_value("R10", v);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_patterns();
    t_partial();
    t_backpressure();
    t_hold_release();
    t_random();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule